// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 64 hardware interrupt inputs, split into a low bank (sources 0 to 31) and a high bank (sources 32 to 63), and folds them into two processor request lines: a normal request `irq` and a fast request `fiq`. Each input is first brought into the clock domain by a synchronizer. It is then treated either as a level, qualified by a programmable polarity, or as an edge (rising, falling or both) that is caught in a sticky latch. Software may also force any source pending through a soft-trigger bit.

Pending sources pass through a per-source enable and a per-source route bit that selects the output line. Software programs the block through a plain single-cycle 32-bit register port. Reads are combinational on the address; a write takes effect at the clock edge where `busWr` is high. Set-type registers (enable, soft trigger) have a companion clear address, and edge latches are released by writing ones to a clear address. Every register has a low-bank word at an even word address and its high-bank twin 4 bytes above.

Register byte offsets (low bank; add 4 for the high bank): 0x00 masked normal status, 0x08 masked fast status, 0x10 unmasked pending, 0x18 route, 0x20 enable set (reads enable), 0x28 enable clear, 0x30 soft-trigger set (reads soft trigger), 0x38 soft-trigger clear, 0x40 level-mode, 0x48 both-edge mode, 0x50 polarity, 0x58 latch clear, 0x60 latch status.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, enable, soft-trigger, route, both-edge, polarity and edge latches are all zero and every level-mode bit is one, so with all inputs low every source reads as pending at offset 0x10 while `irq` and `fiq` stay low.
- R2: Writing ones at 0x20/0x24 sets the addressed enable bits and writing ones at 0x28/0x2C clears them; zero bits leave enables unchanged. The enable value reads back at 0x20/0x24.
- R3: Writing ones at 0x30/0x34 sets soft-trigger bits, which make the source pending at 0x10/0x14. Writing ones at 0x38/0x3C clears them.
- R4: A route bit of 0 sends an enabled pending source to `irq` and status 0x00/0x04. A route bit of 1 sends it to `fiq` and status 0x08/0x0C.
- R5: With its level-mode bit at 1, a source is pending while its synchronized input equals its polarity bit (1 = active high, 0 = active low).
- R6: With its level-mode bit at 0, a source latches a rising edge when polarity is 1 and a falling edge when polarity is 0. When its both-edge bit is 1, it latches both edges whatever the polarity. The latch shows at 0x60/0x64.
- R7: Writing ones at 0x58/0x5C clears the addressed edge latches. On a level-mode source this write leaves its pending state and outputs unchanged.
- R8: If a new edge and a latch-clear write hit the same latch in the same cycle, the latch ends up set.
- R9: `irq` is the OR of all 64 normal-status bits and `fiq` is the OR of all 64 fast-status bits, so both stay low while no source is enabled.
- R10: Bit 2 of the address selects the bank: a write to a high-bank address changes only sources 32 to 63, and a write to a low-bank address changes only sources 0 to 31.
- R11: A set edge latch stays set, whatever its input does, until a latch-clear write or a switch to level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 7 | Byte address of the register port |
| busWdata | input | 32 | Write data |
| busWr | input | 1 | Write strobe, one write per cycle high |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| srcIn | input | 64 | Raw interrupt inputs, bit n is source n |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The edge path is swept over every one of the 64 sources under all four combinations of polarity and both-edge mode. Each input makes a rising and then a falling transition, and the latch word must show exactly the one expected bit, which separates polarity handling, both-edge handling and any cross-talk between sources or banks. The level path is tried in both input states with an inverted polarity on one source against active-low defaults on all others. Routing is tried with one source moved between the two outputs. A directed sequence aligns a fresh edge with a clear write in the same cycle to distinguish set-wins from clear-wins.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int NUM_SRC   = BANK_W * NUM_BANKS;
  localparam int ADDR_W    = 7;

  // register index = byte offset / 8; bit 2 of the address picks the bank
  typedef enum logic [3:0] {
    REG_STS_IRQ  = 4'd0,
    REG_STS_FIQ  = 4'd1,
    REG_RAW      = 4'd2,
    REG_ROUTE    = 4'd3,
    REG_EN_SET   = 4'd4,
    REG_EN_CLR   = 4'd5,
    REG_TRG_SET  = 4'd6,
    REG_TRG_CLR  = 4'd7,
    REG_LEVEL    = 4'd8,
    REG_BOTH     = 4'd9,
    REG_POL      = 4'd10,
    REG_EDGE_CLR = 4'd11,
    REG_EDGE_STS = 4'd12,
    REG_NONE     = 4'd15
  } regId_e;

  typedef struct packed {
    logic   bank;
    regId_e rdReg;
    logic   wrRoute;
    logic   wrEnSet;
    logic   wrEnClr;
    logic   wrTrgSet;
    logic   wrTrgClr;
    logic   wrLevel;
    logic   wrBoth;
    logic   wrPol;
    logic   wrEdgeClr;
  } busCmd_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busCmd_t           cmd
);
  localparam logic [3:0] LAST_REG = 4'(REG_EDGE_STS);

  logic [3:0] regIdx;
  logic       regValid;
  logic       doWr;

  assign regIdx   = busAddr[6:3];
  assign regValid = (regIdx <= LAST_REG);
  assign doWr     = busWr && regValid;

  always_comb begin
    cmd           = '0;
    cmd.bank      = busAddr[2];
    cmd.rdReg     = regValid ? regId_e'(regIdx) : REG_NONE;
    cmd.wrRoute   = doWr && (cmd.rdReg == REG_ROUTE);
    cmd.wrEnSet   = doWr && (cmd.rdReg == REG_EN_SET);
    cmd.wrEnClr   = doWr && (cmd.rdReg == REG_EN_CLR);
    cmd.wrTrgSet  = doWr && (cmd.rdReg == REG_TRG_SET);
    cmd.wrTrgClr  = doWr && (cmd.rdReg == REG_TRG_CLR);
    cmd.wrLevel   = doWr && (cmd.rdReg == REG_LEVEL);
    cmd.wrBoth    = doWr && (cmd.rdReg == REG_BOTH);
    cmd.wrPol     = doWr && (cmd.rdReg == REG_POL);
    cmd.wrEdgeClr = doWr && (cmd.rdReg == REG_EDGE_CLR);
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  busCmd_t            cmd,
  input  logic [BANK_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [BANK_W-1:0]  rdata,
  output logic               irq,
  output logic               fiq
);
  logic [NUM_SRC-1:0] srcSync, srcPrev;
  logic [NUM_SRC-1:0] routeReg, enReg, trgReg, levelReg, bothReg, polReg;
  logic [NUM_SRC-1:0] latchReg, clrVec;
  logic [NUM_SRC-1:0] riseV, fallV, edgeHit, levelHit, pend, stsIrq, stsFiq;

  intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(srcIn), .q(srcSync)
  );

  always_ff @(posedge clk) begin
    if (rst) srcPrev <= '0;
    else     srcPrev <= srcSync;
  end

  // configuration registers, one bank per write
  always_ff @(posedge clk) begin
    if (rst) begin
      routeReg <= '0;
      enReg    <= '0;
      trgReg   <= '0;
      levelReg <= '1;
      bothReg  <= '0;
      polReg   <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(cmd.bank) == b) begin
          if (cmd.wrRoute)  routeReg[b*BANK_W +: BANK_W] <= wdata;
          if (cmd.wrEnSet)  enReg[b*BANK_W +: BANK_W]    <= enReg[b*BANK_W +: BANK_W] | wdata;
          if (cmd.wrEnClr)  enReg[b*BANK_W +: BANK_W]    <= enReg[b*BANK_W +: BANK_W] & ~wdata;
          if (cmd.wrTrgSet) trgReg[b*BANK_W +: BANK_W]   <= trgReg[b*BANK_W +: BANK_W] | wdata;
          if (cmd.wrTrgClr) trgReg[b*BANK_W +: BANK_W]   <= trgReg[b*BANK_W +: BANK_W] & ~wdata;
          if (cmd.wrLevel)  levelReg[b*BANK_W +: BANK_W] <= wdata;
          if (cmd.wrBoth)   bothReg[b*BANK_W +: BANK_W]  <= wdata;
          if (cmd.wrPol)    polReg[b*BANK_W +: BANK_W]   <= wdata;
        end
      end
    end
  end

  // edge detection on synchronized inputs
  assign riseV   = srcSync & ~srcPrev;
  assign fallV   = ~srcSync & srcPrev;
  assign edgeHit = ~levelReg & ((bothReg & (riseV | fallV)) |
                                (~bothReg & polReg & riseV) |
                                (~bothReg & ~polReg & fallV));

  always_comb begin
    clrVec = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (cmd.wrEdgeClr && int'(cmd.bank) == b) clrVec[b*BANK_W +: BANK_W] = wdata;
  end

  // a fresh edge takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) latchReg <= '0;
    else     latchReg <= edgeHit | (latchReg & ~clrVec & ~levelReg);
  end

  assign levelHit = levelReg & ~(srcSync ^ polReg);
  assign pend     = latchReg | levelHit | trgReg;
  assign stsIrq   = pend & enReg & ~routeReg;
  assign stsFiq   = pend & enReg & routeReg;
  assign irq      = |stsIrq;
  assign fiq      = |stsFiq;

  function automatic logic [BANK_W-1:0] pickBank(input logic [NUM_SRC-1:0] v, input logic b);
    return b ? v[NUM_SRC-1 -: BANK_W] : v[BANK_W-1:0];
  endfunction

  always_comb begin
    unique case (cmd.rdReg)
      REG_STS_IRQ:              rdata = pickBank(stsIrq, cmd.bank);
      REG_STS_FIQ:              rdata = pickBank(stsFiq, cmd.bank);
      REG_RAW:                  rdata = pickBank(pend, cmd.bank);
      REG_ROUTE:                rdata = pickBank(routeReg, cmd.bank);
      REG_EN_SET, REG_EN_CLR:   rdata = pickBank(enReg, cmd.bank);
      REG_TRG_SET, REG_TRG_CLR: rdata = pickBank(trgReg, cmd.bank);
      REG_LEVEL:                rdata = pickBank(levelReg, cmd.bank);
      REG_BOTH:                 rdata = pickBank(bothReg, cmd.bank);
      REG_POL:                  rdata = pickBank(polReg, cmd.bank);
      REG_EDGE_STS:             rdata = pickBank(latchReg, cmd.bank);
      default:                  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BANK_W-1:0]  busWdata,
  input  logic               busWr,
  output logic [BANK_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irq,
  output logic               fiq
);
  busCmd_t cmd;

  intc_ctrl u_ctrl (
    .busWr(busWr), .busAddr(busAddr), .cmd(cmd)
  );

  intc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .wdata(busWdata), .srcIn(srcIn),
    .rdata(busRdata), .irq(irq), .fiq(fiq)
  );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input busCmd_t            cmd,
  input logic [BANK_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] enReg,
  input logic [NUM_SRC-1:0] routeReg,
  input logic [NUM_SRC-1:0] latchReg,
  input logic [NUM_SRC-1:0] pend,
  input logic               irq,
  input logic               fiq
);
  // R2
  en_clear_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.wrEnClr && !cmd.bank) |=> ((enReg[BANK_W-1:0] & $past(wdata)) == '0));

  // R2
  en_clear_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.wrEnClr && cmd.bank) |=> ((enReg[NUM_SRC-1 -: BANK_W] & $past(wdata)) == '0));

  // R3
  trg_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.wrTrgSet && !cmd.bank) |=> ((pend[BANK_W-1:0] & $past(wdata)) == $past(wdata)));

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd.wrEdgeClr || cmd.wrLevel) |=> ((latchReg & $past(latchReg)) == $past(latchReg)));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (enReg == '0) |-> (!irq && !fiq));

  // R4
  fast_route_chk: assert property (@(posedge clk) disable iff (rst)
    fiq |-> ((enReg & routeReg) != '0));
endmodule

bind intc_datapath intc_chk u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .wdata(wdata), .enReg(enReg),
  .routeReg(routeReg), .latchReg(latchReg), .pend(pend), .irq(irq), .fiq(fiq)
);

// File: tb/dual_bank_intc_test.sv
module dual_bank_intc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWr = 1'b0;
  logic [31:0] busRdata;
  logic [63:0] srcIn = '0;
  logic        irq, fiq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dual_bank_intc uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .busRdata(busRdata), .srcIn(srcIn), .irq(irq), .fiq(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] rv;
    settle(3);
    rst = 1'b0;
    settle(3);

    // R1 reset state
    rdReg(7'h40, rv); chk("R1 level-mode low", rv, 32'hFFFF_FFFF);
    rdReg(7'h44, rv); chk("R1 level-mode high", rv, 32'hFFFF_FFFF);
    rdReg(7'h20, rv); chk("R1 enable low", rv, 32'h0);
    rdReg(7'h64, rv); chk("R1 latch high", rv, 32'h0);
    rdReg(7'h10, rv); chk("R1 pending low", rv, 32'hFFFF_FFFF);
    chk("R1 irq/fiq idle", {30'b0, irq, fiq}, 32'h0);

    // R2 enable set/clear, R10 bank separation
    wrReg(7'h20, 32'h0000_00F0);
    wrReg(7'h28, 32'h0000_0030);
    rdReg(7'h20, rv); chk("R2 enable low", rv, 32'h0000_00C0);
    wrReg(7'h24, 32'h8000_0001);
    rdReg(7'h24, rv); chk("R10 enable high", rv, 32'h8000_0001);
    rdReg(7'h20, rv); chk("R10 enable low untouched", rv, 32'h0000_00C0);
    wrReg(7'h28, 32'hFFFF_FFFF);
    wrReg(7'h2C, 32'hFFFF_FFFF);
    rdReg(7'h24, rv); chk("R2 enable high cleared", rv, 32'h0);

    // R5 level with polarity on source 3
    wrReg(7'h50, 32'h0000_0008);
    settle(3);
    rdReg(7'h10, rv); chk("R5 active-high idle", rv, 32'hFFFF_FFF7);
    srcIn[3] = 1'b1;
    settle(4);
    rdReg(7'h10, rv); chk("R5 active-high asserted", rv, 32'hFFFF_FFFF);

    // R4 / R9 routing of source 3
    wrReg(7'h20, 32'h0000_0008);
    rdReg(7'h00, rv); chk("R4 normal status", rv, 32'h0000_0008);
    chk("R9 irq only", {30'b0, irq, fiq}, 32'h2);
    wrReg(7'h18, 32'h0000_0008);
    rdReg(7'h08, rv); chk("R4 fast status", rv, 32'h0000_0008);
    rdReg(7'h00, rv); chk("R4 normal status empty", rv, 32'h0);
    chk("R9 fiq only", {30'b0, irq, fiq}, 32'h1);

    // R7 latch clear on level source has no effect
    wrReg(7'h58, 32'hFFFF_FFFF);
    rdReg(7'h08, rv); chk("R7 level survives clear", rv, 32'h0000_0008);
    chk("R7 fiq held", {31'b0, fiq}, 32'h1);
    srcIn[3] = 1'b0;
    settle(4);
    chk("R5 level released", {31'b0, fiq}, 32'h0);
    wrReg(7'h28, 32'hFFFF_FFFF);
    wrReg(7'h18, 32'h0);
    wrReg(7'h50, 32'h0);

    // switch all to edge mode
    wrReg(7'h40, 32'h0);
    wrReg(7'h44, 32'h0);
    settle(2);
    rdReg(7'h10, rv); chk("R6 edge mode idle low", rv, 32'h0);
    rdReg(7'h14, rv); chk("R6 edge mode idle high", rv, 32'h0);

    // R3 soft trigger in the high bank, routed to fiq
    wrReg(7'h34, 32'h0001_0000);
    rdReg(7'h14, rv); chk("R3 trigger pending", rv, 32'h0001_0000);
    rdReg(7'h10, rv); chk("R10 trigger low untouched", rv, 32'h0);
    wrReg(7'h24, 32'h0001_0000);
    wrReg(7'h1C, 32'h0001_0000);
    rdReg(7'h0C, rv); chk("R3 trigger fast status", rv, 32'h0001_0000);
    chk("R4 trigger fiq", {30'b0, irq, fiq}, 32'h1);
    wrReg(7'h3C, 32'h0001_0000);
    rdReg(7'h14, rv); chk("R3 trigger cleared", rv, 32'h0);
    chk("R3 fiq dropped", {31'b0, fiq}, 32'h0);
    wrReg(7'h2C, 32'hFFFF_FFFF);
    wrReg(7'h1C, 32'h0);

    // R6 sweep: every source, every polarity/both-edge mode, both transitions
    for (int i = 0; i < 64; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [6:0]  off;
        logic [31:0] bitv;
        bit          pol, both;
        off  = (i >= 32) ? 7'h4 : 7'h0;
        bitv = 32'h1 << (i % 32);
        pol  = m[0];
        both = m[1];
        wrReg(7'h48 + off, both ? bitv : 32'h0);
        wrReg(7'h50 + off, pol ? bitv : 32'h0);
        wrReg(7'h58 + off, 32'hFFFF_FFFF);
        srcIn[i] = 1'b1;
        settle(4);
        rdReg(7'h60 + off, rv);
        chk($sformatf("R6 rise src%0d mode%0d", i, m), rv, (both || pol) ? bitv : 32'h0);
        wrReg(7'h58 + off, 32'hFFFF_FFFF);
        srcIn[i] = 1'b0;
        settle(4);
        rdReg(7'h60 + off, rv);
        chk($sformatf("R6 fall src%0d mode%0d", i, m), rv, (both || !pol) ? bitv : 32'h0);
        wrReg(7'h58 + off, 32'hFFFF_FFFF);
      end
      wrReg(((i >= 32) ? 7'h4C : 7'h48), 32'h0);
      wrReg(((i >= 32) ? 7'h54 : 7'h50), 32'h0);
    end

    // R8 edge and clear in the same cycle: source 5, rising
    wrReg(7'h50, 32'h0000_0020);
    wrReg(7'h58, 32'hFFFF_FFFF);
    @(negedge clk);
    srcIn[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busAddr = 7'h58; busWdata = 32'h0000_0020; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    rdReg(7'h60, rv); chk("R8 edge beats clear", rv, 32'h0000_0020);

    // R11 latch holds while input changes
    srcIn[5] = 1'b0;
    settle(10);
    rdReg(7'h60, rv); chk("R11 latch held", rv, 32'h0000_0020);
    wrReg(7'h20, 32'h0000_0020);
    chk("R9 latched edge on irq", {30'b0, irq, fiq}, 32'h2);

    // R7 plain clear of an edge latch
    wrReg(7'h58, 32'h0000_0020);
    rdReg(7'h60, rv); chk("R7 latch cleared", rv, 32'h0);
    chk("R7 irq dropped", {31'b0, irq}, 32'h0);

    finishRun();
  end
endmodule